// File: doc/BRIEF.md
# NAND Command/Address Strobe Timing Generator

This block sits between a host register interface and an 8-bit NAND flash bus. It turns three kinds of host request into NAND bus cycles: a write to the command port, a write to the address port, and a request to read one byte. A command write produces a cycle with the command latch enable high. An address write produces a cycle with the address latch enable high. A read request pulses the read strobe and captures the byte the device drives. Each phase of a cycle is stretched by its own cycle-count input: chip-enable setup, bus turnaround, strobe low and strobe high.

Chip enable is driven by the controller. It stays high while the block is idle and goes low for the whole length of each cycle. After each command cycle the block ignores the device ready/busy pin for a programmable delay, so that it never reads a stale ready level. The host sees a single ready flag. The flag is high only when the controller is idle and the device reports ready.

A request that arrives while the block cannot take it is held off by the `stall` output. The host keeps the request asserted until `stall` falls. While the device is busy, the only request the block accepts is the device reset command byte.

Top module: `nand_strobe_gen`

## Requirements
- R1: A command-port request produces one cycle with `nand_cle`=1 and `nand_ale`=0. The byte from `wr_data`, latched when the request is accepted, is on `nand_dq_o` with `nand_dq_oe`=1 for as long as `nand_we_n` is low.
- R2: An address-port request produces one cycle with `nand_ale`=1 and `nand_cle`=0. Its write byte and write strobe behave as in R1.
- R3: In a write cycle `nand_we_n` is low for `t_wr_lo` cycles and then high for `t_wr_hi` cycles. `nand_ce_n` stays low through the high phase and rises at the end of it. `nand_re_n` stays high throughout.
- R4: A read request drives `nand_re_n` low for `t_rd_lo` cycles and then high for `t_rd_hi` cycles, and `nand_we_n` stays high. `nand_dq_i` is captured in the last low cycle. It appears on `rd_data` with a one-cycle `rd_valid` pulse in the first high cycle.
- R5: `nand_ce_n` is high while idle. Once a request is accepted, `nand_ce_n` is low for `t_ce_setup` cycles before the strobe phase begins (or before the turnaround phase, if one is inserted).
- R6: When a cycle's direction differs from the previous cycle's direction, `t_turn` extra cycles are inserted between chip-enable setup and the strobe. Reads count as one direction; commands and addresses count as the other. After reset the previous direction counts as write.
- R7: A value of zero on any timing input is treated as one cycle.
- R8: After a command cycle ends, `host_ready` stays low for `t_busy` cycles whatever the level of `nand_rb`. After that it follows `nand_rb` (1 = ready). Address and read cycles do not start this delay.
- R9: `host_ready` is 1 only when no cycle is in progress and the device is ready. It is never 1 while `nand_ce_n` is low.
- R10: A request made while a cycle is in progress sees `stall`=1 and is not taken. If it is still held, it is accepted in the first idle cycle, so `nand_ce_n` is high for exactly one cycle between the two bus cycles.
- R11: When several requests are raised together, the command request wins over the address request, and the address request wins over the read request.
- R12: While the device is not ready, every request is stalled except a command request with byte 0xFF (the device reset command). That command is accepted at once.
- R13: After reset: `nand_ce_n`, `nand_we_n` and `nand_re_n` are 1; `nand_cle`, `nand_ale`, `nand_dq_oe` and `rd_valid` are 0; `host_ready` equals `nand_rb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command-port write request, held until accepted |
| addr_wr | input | 1 | Address-port write request, held until accepted |
| rd_req | input | 1 | Data read request, held until accepted |
| wr_data | input | 8 | Byte for a command or address write |
| t_wr_lo | input | 4 | Write strobe low time, in cycles |
| t_wr_hi | input | 4 | Write strobe high time, in cycles |
| t_rd_lo | input | 4 | Read strobe low time, in cycles |
| t_rd_hi | input | 4 | Read strobe high time, in cycles |
| t_ce_setup | input | 2 | Chip-enable to first strobe delay, in cycles |
| t_turn | input | 3 | Bus turnaround time, in cycles |
| t_busy | input | 5 | Cycles after a command before ready/busy is trusted |
| nand_rb | input | 1 | Device ready/busy pin, 1 = ready |
| nand_dq_i | input | 8 | Data bus from the device |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Data bus to the device |
| nand_dq_oe | output | 1 | Output enable for nand_dq_o |
| rd_data | output | 8 | Last byte read |
| rd_valid | output | 1 | One-cycle pulse when rd_data is updated |
| host_ready | output | 1 | Controller idle and device ready |
| stall | output | 1 | Request cannot be accepted in this cycle |

## Verification
Two events can fall in the same cycle: a strobe-high phase ends, and a held request waiting behind it is accepted. The bench raises a second address write while the first is still on the bus. It then changes `wr_data`, and checks three things: the first cycle keeps its latched byte, `stall` stays high until the bus goes idle, and `nand_ce_n` is high for exactly one cycle before the second cycle starts with the new byte. A second collision is a reset command that arrives while the busy delay is running or the device pin is low. The bench checks that this command is taken at once while other requests stay stalled.

// File: rtl/nand_strobe_pkg.sv
package nand_strobe_pkg;

    // Bus cycle phases, in the order a cycle walks through them.
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_CE   = 3'd1,
        PH_TURN = 3'd2,
        PH_LO   = 3'd3,
        PH_HI   = 3'd4
    } phase_e;

    // Kind of bus cycle.
    typedef enum logic [1:0] {
        K_CMD  = 2'd0,
        K_ADDR = 2'd1,
        K_READ = 2'd2
    } kind_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/nand_req_arb.sv
module nand_req_arb
    import nand_strobe_pkg::*;
#(
    parameter int          DATA_W   = 8,
    parameter logic [DATA_W-1:0] RST_CODE = 8'hFF
) (
    input  logic              cmd_wr,
    input  logic              addr_wr,
    input  logic              rd_req,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              idle,
    input  logic              dev_rdy,
    output logic              start,
    output kind_e             start_kind,
    output logic              stall
);

    typedef struct packed {
        logic  any;
        logic  rst_cmd;
        logic  allow;
        kind_e kind;
    } arb_t;

    arb_t a_d;

    always_comb begin
        a_d.any     = cmd_wr | addr_wr | rd_req;
        a_d.rst_cmd = cmd_wr && (wr_data == RST_CODE);
        // Fixed priority: command, then address, then read.
        if (cmd_wr) begin
            a_d.kind = K_CMD;
        end else if (addr_wr) begin
            a_d.kind = K_ADDR;
        end else begin
            a_d.kind = K_READ;
        end
        // Busy device: only the reset command may pass.
        a_d.allow = idle && (dev_rdy || a_d.rst_cmd);
    end

    assign start      = a_d.any && a_d.allow;
    assign start_kind = a_d.kind;
    assign stall      = !a_d.allow;

endmodule

// File: rtl/nand_phase_seq.sv
module nand_phase_seq
    import nand_strobe_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int STB_W  = 4,
    parameter int TA_W   = 3,
    parameter int CES_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  kind_e             start_kind,
    input  logic [DATA_W-1:0] start_data,
    input  logic [STB_W-1:0]  t_wr_lo,
    input  logic [STB_W-1:0]  t_wr_hi,
    input  logic [STB_W-1:0]  t_rd_lo,
    input  logic [STB_W-1:0]  t_rd_hi,
    input  logic [CES_W-1:0]  t_ce,
    input  logic [TA_W-1:0]   t_turn,
    input  logic [DATA_W-1:0] dq_i,
    output logic              idle,
    output logic              cmd_done,
    output logic              ce_n,
    output logic              cle,
    output logic              ale,
    output logic              we_n,
    output logic              re_n,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    localparam int CNT_W = max3(STB_W, TA_W, CES_W);

    typedef struct packed {
        phase_e            ph;
        kind_e             kind;
        logic [DATA_W-1:0] data;
        logic [CNT_W-1:0]  cnt;
        logic              turn_pend;
        logic              last_rd;
        logic [DATA_W-1:0] rdat;
        logic              rvld;
    } seq_t;

    seq_t s_d, s_q;

    // A programmed zero still gives a one-cycle phase.
    function automatic logic [CNT_W-1:0] len_of(input logic [CNT_W-1:0] v);
        return (v == '0) ? CNT_W'(1) : v;
    endfunction

    logic             is_rd;
    logic             ph_last;
    logic [CNT_W-1:0] lo_len;
    logic [CNT_W-1:0] hi_len;

    always_comb begin
        is_rd   = (s_q.kind == K_READ);
        ph_last = (s_q.cnt == CNT_W'(1));
        lo_len  = is_rd ? len_of(CNT_W'(t_rd_lo)) : len_of(CNT_W'(t_wr_lo));
        hi_len  = is_rd ? len_of(CNT_W'(t_rd_hi)) : len_of(CNT_W'(t_wr_hi));

        s_d      = s_q;
        s_d.rvld = 1'b0;

        unique case (s_q.ph)
            PH_IDLE: begin
                if (start) begin
                    s_d.ph        = PH_CE;
                    s_d.kind      = start_kind;
                    s_d.data      = start_data;
                    s_d.cnt       = len_of(CNT_W'(t_ce));
                    s_d.turn_pend = ((start_kind == K_READ) != s_q.last_rd);
                end
            end
            PH_CE: begin
                if (!ph_last) begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end else if (s_q.turn_pend) begin
                    s_d.ph  = PH_TURN;
                    s_d.cnt = len_of(CNT_W'(t_turn));
                end else begin
                    s_d.ph  = PH_LO;
                    s_d.cnt = lo_len;
                end
            end
            PH_TURN: begin
                if (!ph_last) begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end else begin
                    s_d.ph  = PH_LO;
                    s_d.cnt = lo_len;
                end
            end
            PH_LO: begin
                if (!ph_last) begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end else begin
                    s_d.ph      = PH_HI;
                    s_d.cnt     = hi_len;
                    s_d.last_rd = is_rd;
                    if (is_rd) begin
                        s_d.rdat = dq_i;
                        s_d.rvld = 1'b1;
                    end
                end
            end
            PH_HI: begin
                if (!ph_last) begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end else begin
                    s_d.ph  = PH_IDLE;
                    s_d.cnt = '0;
                end
            end
            default: begin
                s_d.ph  = PH_IDLE;
                s_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.ph        <= PH_IDLE;
            s_q.kind      <= K_CMD;
            s_q.data      <= '0;
            s_q.cnt       <= '0;
            s_q.turn_pend <= 1'b0;
            s_q.last_rd   <= 1'b0;
            s_q.rdat      <= '0;
            s_q.rvld      <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    // Pin decode from the registered phase.
    assign idle     = (s_q.ph == PH_IDLE);
    assign cmd_done = (s_q.ph == PH_HI) && ph_last && (s_q.kind == K_CMD);
    assign ce_n     = idle;
    assign cle      = !idle && (s_q.kind == K_CMD);
    assign ale      = !idle && (s_q.kind == K_ADDR);
    assign we_n     = !((s_q.ph == PH_LO) && !is_rd);
    assign re_n     = !((s_q.ph == PH_LO) && is_rd);
    assign dq_o     = s_q.data;
    assign dq_oe    = !is_rd && ((s_q.ph == PH_LO) || (s_q.ph == PH_HI));
    assign rd_data  = s_q.rdat;
    assign rd_valid = s_q.rvld;

endmodule

// File: rtl/nand_busy_track.sv
module nand_busy_track #(
    parameter int BSY_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [BSY_W-1:0] t_busy,
    input  logic             rb,
    output logic             dev_rdy
);

    typedef struct packed {
        logic [BSY_W-1:0] cnt;
    } bsy_t;

    bsy_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (arm) begin
            b_d.cnt = (t_busy == '0) ? BSY_W'(1) : t_busy;
        end else if (b_q.cnt != '0) begin
            b_d.cnt = b_q.cnt - BSY_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_q.cnt <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    // The pin is trusted only once the blanking window has run out.
    assign dev_rdy = (b_q.cnt == '0) && rb;

endmodule

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen
    import nand_strobe_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int STB_W  = 4,
    parameter int TA_W   = 3,
    parameter int CES_W  = 2,
    parameter int BSY_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              addr_wr,
    input  logic              rd_req,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [STB_W-1:0]  t_wr_lo,
    input  logic [STB_W-1:0]  t_wr_hi,
    input  logic [STB_W-1:0]  t_rd_lo,
    input  logic [STB_W-1:0]  t_rd_hi,
    input  logic [CES_W-1:0]  t_ce_setup,
    input  logic [TA_W-1:0]   t_turn,
    input  logic [BSY_W-1:0]  t_busy,
    input  logic              nand_rb,
    input  logic [DATA_W-1:0] nand_dq_i,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [DATA_W-1:0] nand_dq_o,
    output logic              nand_dq_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              host_ready,
    output logic              stall
);

    logic  idle;
    logic  dev_rdy;
    logic  start;
    kind_e start_kind;
    logic  cmd_done;

    nand_req_arb #(
        .DATA_W   (DATA_W),
        .RST_CODE ({DATA_W{1'b1}})
    ) u_arb (
        .cmd_wr     (cmd_wr),
        .addr_wr    (addr_wr),
        .rd_req     (rd_req),
        .wr_data    (wr_data),
        .idle       (idle),
        .dev_rdy    (dev_rdy),
        .start      (start),
        .start_kind (start_kind),
        .stall      (stall)
    );

    nand_phase_seq #(
        .DATA_W (DATA_W),
        .STB_W  (STB_W),
        .TA_W   (TA_W),
        .CES_W  (CES_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_kind (start_kind),
        .start_data (wr_data),
        .t_wr_lo    (t_wr_lo),
        .t_wr_hi    (t_wr_hi),
        .t_rd_lo    (t_rd_lo),
        .t_rd_hi    (t_rd_hi),
        .t_ce       (t_ce_setup),
        .t_turn     (t_turn),
        .dq_i       (nand_dq_i),
        .idle       (idle),
        .cmd_done   (cmd_done),
        .ce_n       (nand_ce_n),
        .cle        (nand_cle),
        .ale        (nand_ale),
        .we_n       (nand_we_n),
        .re_n       (nand_re_n),
        .dq_o       (nand_dq_o),
        .dq_oe      (nand_dq_oe),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid)
    );

    nand_busy_track #(
        .BSY_W (BSY_W)
    ) u_bsy (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (cmd_done),
        .t_busy  (t_busy),
        .rb      (nand_rb),
        .dev_rdy (dev_rdy)
    );

    assign host_ready = idle && dev_rdy;

endmodule

// File: rtl/nand_strobe_chk.sv
module nand_strobe_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              nand_ce_n,
    input logic              nand_cle,
    input logic              nand_ale,
    input logic              nand_we_n,
    input logic              nand_re_n,
    input logic [DATA_W-1:0] nand_dq_o,
    input logic              nand_dq_oe,
    input logic              rd_valid,
    input logic              host_ready,
    input logic              stall
);

    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));

    p_latch_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    p_ce_covers_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

    p_dq_driven_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |-> nand_dq_oe);

    p_dq_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n && $past(!nand_we_n)) |-> $stable(nand_dq_o));

    p_latch_at_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nand_we_n) |-> (nand_cle || nand_ale));

    p_rd_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(!nand_re_n) && nand_re_n));

    p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> nand_ce_n);

    p_stall_in_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_ce_n |-> stall);

endmodule

bind nand_strobe_gen nand_strobe_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .nand_ce_n  (nand_ce_n),
    .nand_cle   (nand_cle),
    .nand_ale   (nand_ale),
    .nand_we_n  (nand_we_n),
    .nand_re_n  (nand_re_n),
    .nand_dq_o  (nand_dq_o),
    .nand_dq_oe (nand_dq_oe),
    .rd_valid   (rd_valid),
    .host_ready (host_ready),
    .stall      (stall)
);

// File: tb/nand_strobe_gen_bench.sv
`timescale 1ns/1ps
module nand_strobe_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_wr = 1'b0, addr_wr = 1'b0, rd_req = 1'b0;
    logic [7:0] wr_data = '0;
    logic [3:0] t_wr_lo = 4'd1, t_wr_hi = 4'd1, t_rd_lo = 4'd1, t_rd_hi = 4'd1;
    logic [1:0] t_ce_setup = 2'd1;
    logic [2:0] t_turn = 3'd1;
    logic [4:0] t_busy = 5'd1;
    logic       nand_rb = 1'b1;
    logic [7:0] nand_dq_i = '0;
    logic       nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n;
    logic [7:0] nand_dq_o;
    logic       nand_dq_oe;
    logic [7:0] rd_data;
    logic       rd_valid, host_ready, stall;

    always #10 clk = ~clk;

    nand_strobe_gen u_nand_strobe_gen (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .addr_wr(addr_wr), .rd_req(rd_req),
        .wr_data(wr_data), .t_wr_lo(t_wr_lo), .t_wr_hi(t_wr_hi), .t_rd_lo(t_rd_lo),
        .t_rd_hi(t_rd_hi), .t_ce_setup(t_ce_setup), .t_turn(t_turn), .t_busy(t_busy),
        .nand_rb(nand_rb), .nand_dq_i(nand_dq_i), .nand_ce_n(nand_ce_n),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe),
        .rd_data(rd_data), .rd_valid(rd_valid), .host_ready(host_ready), .stall(stall)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Stimulus and expected values: mask 1=cmd 2=addr 4=read.
    typedef struct packed {
        int mask; int data;
        int wlo; int whi; int rlo; int rhi; int tce; int tturn; int tbusy;
        int e_pre; int e_lo; int e_hi; int e_busy;
    } vec_t;

    localparam vec_t TBL [8] = '{
        '{1, 'h00,  2,  3, 0, 0, 1, 2,  4,   1,  2,  3,  4},
        '{2, 'h12,  1,  1, 0, 0, 2, 3,  9,   2,  1,  1,  0},
        '{4, 'h00,  0,  0, 3, 2, 1, 2,  0,   3,  3,  2,  0},
        '{4, 'h00,  9,  9, 0, 0, 0, 5,  0,   1,  1,  1,  0},
        '{1, 'h30,  0,  0, 4, 4, 3, 0,  0,   4,  1,  1,  1},
        '{2, 'hA5, 15, 15, 0, 0, 3, 7,  2,   3, 15, 15,  0},
        '{1, 'h70,  4,  2, 0, 0, 2, 1, 31,   2,  4,  2, 31},
        '{4, 'h00,  1,  1, 7, 1, 2, 7,  0,   9,  7,  1,  0}
    };

    // Results of the last observed bus cycle.
    int m_pre, m_lo, m_hi, m_busy, m_wrong, m_rdy_in, m_rvld;
    int m_cle, m_ale, m_dq, m_oe;

    task automatic run(input int mask, input logic [7:0] d);
        int w;
        cmd_wr  = mask[0];
        addr_wr = mask[1];
        rd_req  = mask[2];
        wr_data = d;
        #1;
        w = 0;
        while (stall && w < 100) begin
            @(negedge clk); #1; w++;
        end
        @(posedge clk); #1;
        cmd_wr = 0; addr_wr = 0; rd_req = 0;
        m_pre = 0; m_lo = 0; m_hi = 0; m_wrong = 0; m_rdy_in = 0; m_rvld = 0;
        m_cle = 0; m_ale = 0; m_dq = 0; m_oe = 0;
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            if (nand_ce_n) break;
            if (host_ready) m_rdy_in++;
            if (rd_valid) m_rvld++;
            if (!nand_we_n || !nand_re_n) begin
                m_lo++;
                if (!nand_we_n && mask[2] && !mask[0] && !mask[1]) m_wrong++;
                if (!nand_re_n && (mask[0] || mask[1])) m_wrong++;
                m_cle = nand_cle; m_ale = nand_ale; m_dq = nand_dq_o; m_oe = nand_dq_oe;
            end else if (m_lo == 0) begin
                m_pre++;
            end else begin
                m_hi++;
            end
        end
        m_busy = 0;
        while (!host_ready && m_busy < 64) begin
            m_busy++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // Reset state (R13)
        chk("R13 ce_n", nand_ce_n, 1);
        chk("R13 we_n/re_n", {nand_we_n, nand_re_n}, 3);
        chk("R13 cle/ale/oe/rvld", {nand_cle, nand_ale, nand_dq_oe, rd_valid}, 0);
        chk("R13 host_ready", host_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk
        for (int i = 0; i < 8; i++) begin
            t_wr_lo = 4'(TBL[i].wlo); t_wr_hi = 4'(TBL[i].whi);
            t_rd_lo = 4'(TBL[i].rlo); t_rd_hi = 4'(TBL[i].rhi);
            t_ce_setup = 2'(TBL[i].tce); t_turn = 3'(TBL[i].tturn);
            t_busy = 5'(TBL[i].tbusy);
            nand_dq_i = 8'h3C + 8'(i);
            run(TBL[i].mask, 8'(TBL[i].data));
            chk("R5 R6 R7 setup+turnaround", m_pre, TBL[i].e_pre);
            chk("R3 R4 R7 strobe low", m_lo, TBL[i].e_lo);
            chk("R3 R4 R7 strobe high", m_hi, TBL[i].e_hi);
            chk("R8 busy window", m_busy, TBL[i].e_busy);
            chk("R9 ready during cycle", m_rdy_in, 0);
            chk("R3 R4 strobe choice", m_wrong, 0);
            if (TBL[i].mask == 4) begin
                chk("R4 rd_data", rd_data, 8'h3C + i);
                chk("R4 rd_valid pulses", m_rvld, 1);
            end else begin
                chk("R1 R2 cle", m_cle, (TBL[i].mask == 1) ? 1 : 0);
                chk("R1 R2 ale", m_ale, (TBL[i].mask == 2) ? 1 : 0);
                chk("R1 R2 dq", m_dq, TBL[i].data);
                chk("R1 dq_oe", m_oe, 1);
                chk("R4 no rd_valid on write", m_rvld, 0);
            end
        end

        // R10: back-to-back address writes, second held by stall
        begin
            int ph, gap, dq1, dq2, stall_low;
            t_wr_lo = 4'd2; t_wr_hi = 4'd2; t_ce_setup = 2'd1; t_turn = 3'd1;
            ph = 0; gap = 0; dq1 = -1; dq2 = -1; stall_low = 0;
            addr_wr = 1; wr_data = 8'h11;
            @(posedge clk); #1;
            wr_data = 8'h22;
            for (int c = 0; c < 200; c++) begin
                @(negedge clk); #1;
                if (ph == 0) begin
                    if (!nand_we_n) dq1 = nand_dq_o;
                    if (!nand_ce_n && !stall) stall_low++;
                    if (nand_ce_n) begin ph = 1; gap = 1; end
                end else if (ph == 1) begin
                    if (nand_ce_n) gap++;
                    else begin ph = 2; addr_wr = 0; end
                end else begin
                    if (!nand_we_n) dq2 = nand_dq_o;
                    if (nand_ce_n) break;
                end
            end
            chk("R10 stall during cycle", stall_low, 0);
            chk("R10 first byte kept", dq1, 'h11);
            chk("R10 idle gap", gap, 1);
            chk("R10 second byte", dq2, 'h22);
        end

        // R11: all three requests together, command wins
        @(negedge clk);
        run(7, 8'h90);
        chk("R11 cle wins", m_cle, 1);
        chk("R11 ale not set", m_ale, 0);
        chk("R11 write strobe", m_wrong, 0);

        // R12 / R8: device held busy
        t_busy = 5'd3; nand_rb = 1'b0;
        run(1, 8'h60);
        chk("R8 ready follows rb low", m_busy, 64);
        addr_wr = 1; wr_data = 8'h44; #1;
        begin
            int ce_seen = 0, st = 0;
            for (int c = 0; c < 5; c++) begin
                @(negedge clk); #1;
                if (!nand_ce_n) ce_seen++;
                if (stall) st++;
            end
            chk("R12 address stalled", st, 5);
            chk("R12 no bus cycle", ce_seen, 0);
        end
        addr_wr = 0;
        cmd_wr = 1; wr_data = 8'h55; #1;
        chk("R12 other cmd stalled", stall, 1);
        wr_data = 8'hFF; #1;
        chk("R12 reset cmd accepted", stall, 0);
        run(1, 8'hFF);
        chk("R12 reset cmd on bus", m_dq, 'hFF);
        chk("R12 reset cmd cle", m_cle, 1);
        nand_rb = 1'b1; #1;
        chk("R8 ready after rb", host_ready, 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R10 actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule